// File: doc/BRIEF.md
# Pointer Load/Store Address Generator

This block turns a decoded data-transfer operation of a small 8-bit processor into a memory access. It takes three 16-bit pointer values (called X, Y and Z), an 8-bit extension value, and the fields of the operation. The operation fields are the pointer select, the addressing mode, the direction (load or store), the target space (data or program memory), an extended-address flag, an implicit-destination flag, a destination register index and a 6-bit displacement.

One register stage after an operation is accepted, the block presents the following:
- the effective address;
- whether the access is a store and whether it goes to program memory;
- the new pointer value, with a write-back enable and the pointer to update;
- the destination register index, with its enable for loads.

Operations that cannot be encoded raise an error pulse instead. The unit stays busy for the extra cycles the operation needs, and it accepts new work only while it is not busy. The register file, the memories and instruction decode sit outside the block.

Top module: `ptr_agu`

## Requirements
- R1: Post-increment (mode code 1) accesses at the current pointer and writes back pointer+1, wrapping from 0xFFFF to 0x0000.
- R2: Pre-decrement (mode code 2) writes back pointer-1, wrapping from 0x0000 to 0xFFFF, and accesses at that decremented value.
- R3: Displacement (mode code 3, Y or Z only) accesses at pointer plus the unsigned 6-bit displacement, modulo 2^16, and asserts no write-back.
- R4: Plain mode (mode code 0) accesses at the pointer and asserts no write-back. The pointer select codes are 0 = X, 1 = Y and 2 = Z.
- R5: A program-memory access with the extended flag set has an address whose upper 8 bits are the extension value and whose lower 16 bits are the pointer. Every other access has its upper 8 address bits at zero.
- R6: A program-memory load with the implicit flag set targets register index 0. Every other load targets the supplied index. Stores assert no destination enable.
- R7: Counted from acceptance, the total cycles are as follows, and busy is high for that total minus one:
  - a program-memory load takes 3;
  - a data access in pre-decrement or displacement mode takes 2;
  - a data access in plain or post-increment mode takes 1.
- R8: An operation presented while busy is high is ignored and produces no output.
- R9: The following operations are illegal:
  - displacement with X;
  - select code 3;
  - a program-memory store;
  - a program-memory access through X or Y;
  - a program-memory access in pre-decrement or displacement mode.

  An illegal operation produces a one-cycle err pulse, with no access valid, no write-back, no destination enable and no busy.
- R10: Results appear in the cycle after acceptance for exactly one cycle, so single-cycle operations can be issued back to back.
- R11: After synchronous reset, acc_valid, err, wb_en, dst_en and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 illegal |
| op_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| op_store | input | 1 | 1 store, 0 load |
| op_prog | input | 1 | Target is program memory |
| op_ext | input | 1 | Prefix the extension value to a program address |
| op_implicit | input | 1 | Program load targets register 0 |
| op_rd | input | 5 | Destination register index |
| op_disp | input | 6 | Unsigned displacement |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| ext_hi | input | 8 | Address extension value |
| busy | output | 1 | Unit occupied, new operations ignored |
| acc_valid | output | 1 | Access result valid |
| acc_addr | output | 24 | Effective address |
| acc_store | output | 1 | Access is a store |
| acc_prog | output | 1 | Access targets program memory |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to update |
| wb_value | output | 16 | New pointer value |
| dst_en | output | 1 | Load destination enable |
| dst_idx | output | 5 | Load destination register index |
| err | output | 1 | Illegal operation pulse |

## Verification
The hardest situation to reach is an operation arriving while the unit is still occupied by a longer one. The stimulus holds a second request on op_valid throughout both busy cycles of a program-memory load and confirms that only one result comes out. Pointer wrap at both ends and displacement carry past 0xFFFF need chosen pointer values near the boundaries. Back-to-back single-cycle operations test that results neither merge nor repeat.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [1:0] {
        SEL_X    = 2'd0,
        SEL_Y    = 2'd1,
        SEL_Z    = 2'd2,
        SEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } amode_e;

    localparam int CYC_PROG  = 3;
    localparam int CYC_LONG  = 2;
    localparam int CYC_SHORT = 1;
    localparam int CNT_W     = $clog2(CYC_PROG + 1);

    typedef struct packed {
        logic             legal;
        logic [CNT_W-1:0] cycles;
        logic             ptr_wb;
        logic             dst_en;
    } agu_ctl_t;

    function automatic logic op_is_legal(ptr_sel_e sel, amode_e mode,
                                         logic store, logic prog);
        logic ok;
        ok = (sel != SEL_NONE);
        if (mode == AM_DISP && sel == SEL_X) ok = 1'b0;
        if (prog && (store || sel != SEL_Z ||
                     mode == AM_PREDEC || mode == AM_DISP)) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [CNT_W-1:0] op_cycles(amode_e mode, logic prog);
        if (prog) return CNT_W'(CYC_PROG);
        if (mode == AM_PREDEC || mode == AM_DISP) return CNT_W'(CYC_LONG);
        return CNT_W'(CYC_SHORT);
    endfunction

endpackage

// File: rtl/ptr_agu_decode.sv
module ptr_agu_decode
    import ptr_agu_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  ptr_sel_e           sel,
    input  amode_e             mode,
    input  logic               store,
    input  logic               prog,
    input  logic               implicit_dst,
    input  logic [RIDX_W-1:0]  rd,
    output agu_ctl_t           ctl,
    output logic [RIDX_W-1:0]  dst_idx
);
    logic legal;

    always_comb begin
        legal       = op_is_legal(sel, mode, store, prog);
        ctl.legal   = legal;
        ctl.cycles  = legal ? op_cycles(mode, prog) : CNT_W'(CYC_SHORT);
        ctl.ptr_wb  = legal && (mode == AM_POSTINC || mode == AM_PREDEC);
        ctl.dst_en  = legal && !store;
        dst_idx     = (prog && implicit_dst) ? '0 : rd;
    end
endmodule

// File: rtl/ptr_agu_addr.sv
module ptr_agu_addr
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int EXT_W  = 8,
    parameter int DISP_W = 6,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  ptr_sel_e            sel,
    input  amode_e              mode,
    input  logic                prog,
    input  logic                ext,
    input  logic [DISP_W-1:0]   disp,
    input  logic [PTR_W-1:0]    ptr_x,
    input  logic [PTR_W-1:0]    ptr_y,
    input  logic [PTR_W-1:0]    ptr_z,
    input  logic [EXT_W-1:0]    ext_hi,
    output logic [ADDR_W-1:0]   addr,
    output logic [PTR_W-1:0]    new_ptr
);
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] low;

    always_comb begin
        unique case (sel)
            SEL_X:   base = ptr_x;
            SEL_Y:   base = ptr_y;
            default: base = ptr_z;
        endcase
    end

    always_comb begin
        new_ptr = base;
        low     = base;
        unique case (mode)
            AM_POSTINC: new_ptr = base + PTR_W'(1);
            AM_PREDEC: begin
                new_ptr = base - PTR_W'(1);
                low     = new_ptr;
            end
            AM_DISP:    low = base + PTR_W'(disp);
            default:    ;
        endcase
    end

    generate
        if (EXT_W > 0) begin : g_ext
            assign addr = (prog && ext) ? {ext_hi, low} : {{EXT_W{1'b0}}, low};
        end else begin : g_noext
            assign addr = low;
        end
    endgenerate
endmodule

// File: rtl/ptr_agu_seq.sv
module ptr_agu_seq
    import ptr_agu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= cycles - CNT_W'(1);
        else if (remain != '0)
            remain <= remain - CNT_W'(1);
    end

    assign busy = (remain != '0);

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7
    remain_range_chk: assert property (@(posedge clk) disable iff (rst)
        remain < CNT_W'(CYC_PROG));

    // R7
    busy_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (remain < $past(remain)));
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int EXT_W  = 8,
    parameter int DISP_W = 6,
    parameter int RIDX_W = 5,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        op_mode,
    input  logic              op_store,
    input  logic              op_prog,
    input  logic              op_ext,
    input  logic              op_implicit,
    input  logic [RIDX_W-1:0] op_rd,
    input  logic [DISP_W-1:0] op_disp,
    input  logic [PTR_W-1:0]  ptr_x,
    input  logic [PTR_W-1:0]  ptr_y,
    input  logic [PTR_W-1:0]  ptr_z,
    input  logic [EXT_W-1:0]  ext_hi,
    output logic              busy,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_store,
    output logic              acc_prog,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [PTR_W-1:0]  wb_value,
    output logic              dst_en,
    output logic [RIDX_W-1:0] dst_idx,
    output logic              err
);
    ptr_sel_e          sel;
    amode_e            mode;
    agu_ctl_t          ctl;
    logic [RIDX_W-1:0] dec_idx;
    logic [ADDR_W-1:0] calc_addr;
    logic [PTR_W-1:0]  calc_ptr;
    logic              accept;

    assign sel    = ptr_sel_e'(op_sel);
    assign mode   = amode_e'(op_mode);
    assign accept = op_valid && !busy;

    ptr_agu_decode #(.RIDX_W(RIDX_W)) u_dec (
        .sel(sel), .mode(mode), .store(op_store), .prog(op_prog),
        .implicit_dst(op_implicit), .rd(op_rd), .ctl(ctl), .dst_idx(dec_idx)
    );

    ptr_agu_addr #(.PTR_W(PTR_W), .EXT_W(EXT_W), .DISP_W(DISP_W)) u_addr (
        .sel(sel), .mode(mode), .prog(op_prog), .ext(op_ext), .disp(op_disp),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .ext_hi(ext_hi),
        .addr(calc_addr), .new_ptr(calc_ptr)
    );

    ptr_agu_seq u_seq (
        .clk(clk), .rst(rst), .start(accept), .cycles(ctl.cycles), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            acc_addr  <= '0;
            acc_store <= 1'b0;
            acc_prog  <= 1'b0;
            wb_en     <= 1'b0;
            wb_sel    <= '0;
            wb_value  <= '0;
            dst_en    <= 1'b0;
            dst_idx   <= '0;
            err       <= 1'b0;
        end else begin
            acc_valid <= accept && ctl.legal;
            err       <= accept && !ctl.legal;
            wb_en     <= accept && ctl.ptr_wb;
            dst_en    <= accept && ctl.dst_en;
            if (accept) begin
                acc_addr  <= calc_addr;
                acc_store <= op_store;
                acc_prog  <= op_prog;
                wb_sel    <= op_sel;
                wb_value  <= calc_ptr;
                dst_idx   <= dec_idx;
            end
        end
    end

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!acc_valid && !wb_en && !dst_en));

    // R7
    prog_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_prog) |-> busy);

    // R3
    wb_needs_acc_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> acc_valid);

    // R6
    store_nodst_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_store) |-> !dst_en);

    // R9
    err_nobusy_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);
endmodule

// File: tb/ptr_agu_test.sv
`timescale 1ns/1ps
module ptr_agu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [1:0]  op_mode = '0;
    logic        op_store = 1'b0;
    logic        op_prog = 1'b0;
    logic        op_ext = 1'b0;
    logic        op_implicit = 1'b0;
    logic [4:0]  op_rd = '0;
    logic [5:0]  op_disp = '0;
    logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic [7:0]  ext_hi = '0;
    logic        busy, acc_valid, acc_store, acc_prog, wb_en, dst_en, err;
    logic [23:0] acc_addr;
    logic [1:0]  wb_sel;
    logic [15:0] wb_value;
    logic [4:0]  dst_idx;

    int compared = 0;
    int mismatched = 0;
    int outputs_seen = 0;
    int outputs_expected = 0;

    typedef struct {
        string       req;
        logic        err;
        logic [23:0] addr;
        logic        store;
        logic        prog;
        logic        wb_en;
        logic [1:0]  wb_sel;
        logic [15:0] wb_value;
        logic        dst_en;
        logic [4:0]  dst_idx;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    ptr_agu uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .op_mode(op_mode), .op_store(op_store), .op_prog(op_prog),
        .op_ext(op_ext), .op_implicit(op_implicit), .op_rd(op_rd),
        .op_disp(op_disp), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .ext_hi(ext_hi), .busy(busy), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_store(acc_store), .acc_prog(acc_prog),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value),
        .dst_en(dst_en), .dst_idx(dst_idx), .err(err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp_v, string what);
        compared++;
        if (act !== exp_v) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    // Monitor: compares every result against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && (acc_valid || err)) begin
            outputs_seen++;
            if (sb.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R8 unexpected result: actual addr %0h err %0b expected none",
                         acc_addr, err);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, {31'd0, err}, {31'd0, e.err}, "err");
                check(e.req, {31'd0, acc_valid}, {31'd0, !e.err}, "acc_valid");
                check(e.req, {31'd0, wb_en}, {31'd0, e.wb_en}, "wb_en");
                check(e.req, {31'd0, dst_en}, {31'd0, e.dst_en}, "dst_en");
                if (!e.err) begin
                    check(e.req, {8'd0, acc_addr}, {8'd0, e.addr}, "addr");
                    check(e.req, {31'd0, acc_store}, {31'd0, e.store}, "store");
                    check(e.req, {31'd0, acc_prog}, {31'd0, e.prog}, "prog");
                end
                if (e.wb_en) begin
                    check(e.req, {30'd0, wb_sel}, {30'd0, e.wb_sel}, "wb_sel");
                    check(e.req, {16'd0, wb_value}, {16'd0, e.wb_value}, "wb_value");
                end
                if (e.dst_en)
                    check(e.req, {27'd0, dst_idx}, {27'd0, e.dst_idx}, "dst_idx");
            end
        end
    end

    // Driver: called at a negedge, presents one operation, predicts its result
    // and busy profile from the requirements, and returns at the negedge on
    // which the unit can take the next one.
    task automatic issue(string req, logic [1:0] sel, logic [1:0] mode,
                         logic st, logic pg, logic ex, logic im,
                         logic [4:0] rd, logic [5:0] q);
        exp_t e;
        logic [15:0] p;
        logic [15:0] low;
        logic [15:0] np;
        int cyc;
        logic legal;
        p = (sel == 2'd0) ? ptr_x : (sel == 2'd1) ? ptr_y : ptr_z;
        legal = (sel != 2'd3) && !(mode == 2'd3 && sel == 2'd0) &&
                !(pg && (st || sel != 2'd2 || mode >= 2'd2));
        np = p; low = p;
        case (mode)
            2'd1: np = p + 16'd1;
            2'd2: begin np = p - 16'd1; low = np; end
            2'd3: low = p + {10'd0, q};
            default: ;
        endcase
        cyc = !legal ? 1 : pg ? 3 : (mode >= 2'd2) ? 2 : 1;
        e.req = req;
        e.err = !legal;
        e.addr = (pg && ex) ? {ext_hi, low} : {8'd0, low};
        e.store = st;
        e.prog = pg;
        e.wb_en = legal && (mode == 2'd1 || mode == 2'd2);
        e.wb_sel = sel;
        e.wb_value = np;
        e.dst_en = legal && !st;
        e.dst_idx = (pg && im) ? 5'd0 : rd;
        sb.push_back(e);
        outputs_expected++;
        op_sel = sel; op_mode = mode; op_store = st; op_prog = pg;
        op_ext = ex; op_implicit = im; op_rd = rd; op_disp = q;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check({"R7 ", req}, {31'd0, busy}, {31'd0, (cyc > 1)}, "busy after accept");
        if (cyc > 1) begin
            repeat (cyc - 1) @(negedge clk);
            check({"R7 ", req}, {31'd0, busy}, 32'd0, "busy released");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11", {27'd0, acc_valid, err, wb_en, dst_en, busy}, 32'd0, "outputs after reset");

        // R4 plain load through X
        ptr_x = 16'h1234; ptr_y = 16'h00FF; ptr_z = 16'h0800; ext_hi = 8'h5A;
        issue("R4 plain X", 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 6'd0);
        // R1 post-increment store via Y, then back-to-back R10
        issue("R1 postinc Y", 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd4, 6'd0);
        ptr_x = 16'hFFFF;
        issue("R1 R10 postinc wrap X", 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 6'd0);
        // R2 pre-decrement
        issue("R2 predec Z", 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 5'd6, 6'd0);
        ptr_x = 16'h0000;
        issue("R2 predec wrap X", 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 6'd0);
        // R3 displacement
        ptr_y = 16'h1000;
        issue("R3 disp Y max", 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 6'd63);
        ptr_z = 16'hFFF0;
        issue("R3 disp Z wrap", 2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd12, 6'h20);
        // R9 illegal forms
        issue("R9 disp X", 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 6'd5);
        issue("R9 sel 3", 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 6'd0);
        issue("R9 prog store", 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd1, 6'd0);
        issue("R9 prog via Y", 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 6'd0);
        issue("R9 prog predec", 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 6'd0);
        // R5 R6 program loads
        ptr_z = 16'h1357;
        issue("R5 R6 prog ext implicit", 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd9, 6'd0);
        issue("R5 R6 prog postinc rd", 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd7, 6'd0);
        // R6 implicit flag has no effect on a data load
        issue("R6 data load implicit", 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd9, 6'd0);
        // R5 ext flag has no effect on a data access
        issue("R5 data ext ignored", 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2, 6'd0);

        // R8 a request held through both busy cycles is ignored
        begin
            exp_t e;
            e.req = "R8 prog load"; e.err = 1'b0; e.addr = {8'h5A, 16'h1357};
            e.store = 1'b0; e.prog = 1'b1; e.wb_en = 1'b0; e.wb_sel = 2'd2;
            e.wb_value = 16'h1357; e.dst_en = 1'b1; e.dst_idx = 5'd0;
            sb.push_back(e);
            outputs_expected++;
            op_sel = 2'd2; op_mode = 2'd0; op_store = 1'b0; op_prog = 1'b1;
            op_ext = 1'b1; op_implicit = 1'b1; op_rd = 5'd11; op_disp = '0;
            op_valid = 1'b1;
            @(negedge clk);
            op_sel = 2'd0; op_mode = 2'd1; op_prog = 1'b0; op_store = 1'b1;
            repeat (2) @(negedge clk);
            op_valid = 1'b0;
            check("R8", {31'd0, busy}, 32'd0, "busy after ignored window");
            repeat (3) @(negedge clk);
            check("R8", outputs_seen, outputs_expected, "result count");
        end

        check("R10", sb.size(), 32'd0, "scoreboard drained");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule